// File: doc/BRIEF.md
# Lookahead-Pipelined First-Order Recursive Filter

This block computes the first-order recursive filter y(n) = x(n) + A·y(n-1) on a stream of signed fixed-point samples. The recursion is not built directly. It is expanded by one step into y(n) = x(n) + A·x(n-1) + A²·y(n-2). The squared coefficient is worked out when the design is elaborated. The feedback loop therefore holds two registers, and the loop multiplier sits between them. The adder is the only logic that follows the second register, which shortens the critical path of the loop.

The input term A·x(n-1) is formed outside the loop. Its register comes after the multiplier on the input path. A sample is taken on every clock cycle in which `in_valid` is high. The matching output appears one cycle later, flagged by `out_valid`. The coefficient A is an elaboration-time parameter with F fractional bits.

Top module: `lapiir_top`

## Requirements
- R1: A synchronous active-high `rst` clears every state register. In the cycle after reset, `y_out` is 0 and `out_valid` is 0.
- R2: `out_valid` is high in exactly those cycles that directly follow a cycle with `in_valid` high.
- R3: For each accepted sample n, `y_out` equals x(n) + T(A·x(n-1)) + T(A2·y(n-2)). In this sum, T(p) is p shifted arithmetically right by F bits and kept to the low DW bits as two's complement. x and y count accepted samples only.
- R4: A2 equals (A·A) shifted arithmetically right by F bits and kept to CW bits as two's complement. It is fixed at elaboration.
- R5: After reset, x(-1), y(-1) and y(-2) are all zero. The first output is therefore x(0), and the second is x(1) + T(A·x(0)).
- R6: In a cycle with `in_valid` low, `x_in` is ignored. `y_out` holds its value, and the filter state does not advance.
- R7: When A is a whole number (a multiple of 2^F), the output equals the plain recursion y(n) = x(n) + T(A·y(n-1)) exactly.
- R8: The final sum wraps modulo 2^DW in two's complement. For example, with A = 1.0, two samples of the largest positive value give -2 when DW = 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample enable for `x_in` |
| x_in | input | DW | Signed input sample |
| out_valid | output | 1 | High one cycle after an accepted sample |
| y_out | output | DW | Signed filter output, held between samples |

## Verification
The assertions assume that `in_valid` and `rst` are never unknown. They also assume that `x_in` may take any value in a cycle where it is not sampled. The stimulus drives defined values on every cycle. It deliberately puts junk values on `x_in` during gap cycles, so the hold rule is tested against real changes on the input. Several coefficient values are instantiated side by side: a fraction, an odd fraction, +1 and -1. They all take the same full sweep of input codes, with gaps and a reset in the middle of the run. The whole-number coefficients are also compared with the plain single-delay recursion.

// File: rtl/lapiir_pkg.sv
package lapiir_pkg;

    // Keep the low w bits of v as a signed two's-complement value.
    function automatic longint wrap_bits(input longint v, input int w);
        longint t;
        t = v <<< (64 - w);
        return t >>> (64 - w);
    endfunction

    // Squared loop coefficient, computed at elaboration.
    function automatic longint sq_coef(input longint a, input int f, input int cw);
        return wrap_bits((a * a) >>> f, cw);
    endfunction

endpackage

// File: rtl/lapiir_fx_mul.sv
module lapiir_fx_mul #(
    parameter int DW   = 12,
    parameter int CW   = 10,
    parameter int F    = 6,
    parameter int COEF = 32
) (
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] dout
);
    localparam int PW = DW + CW;
    localparam logic signed [CW-1:0] CC = CW'(COEF);

    logic signed [PW-1:0] d_ext;
    logic signed [PW-1:0] c_ext;
    logic signed [PW-1:0] prod;

    always_comb begin
        d_ext = PW'(din);
        c_ext = PW'(CC);
        prod  = d_ext * c_ext;
        dout  = DW'(prod >>> F);
    end
endmodule

// File: rtl/lapiir_ff_path.sv
module lapiir_ff_path #(
    parameter int DW   = 12,
    parameter int CW   = 10,
    parameter int F    = 6,
    parameter int COEF = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [DW-1:0] x_in,
    output logic signed [DW-1:0] ff_q
);
    logic signed [DW-1:0] scaled;

    lapiir_fx_mul #(.DW(DW), .CW(CW), .F(F), .COEF(COEF)) u_mul (
        .din  (x_in),
        .dout (scaled)
    );

    // Register after the multiplier: holds T(A*x(n-1)) when sample n arrives.
    always_ff @(posedge clk) begin
        if (rst)     ff_q <= '0;
        else if (en) ff_q <= scaled;
    end

    a_r6_ff_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(ff_q));
endmodule

// File: rtl/lapiir_loop.sv
module lapiir_loop #(
    parameter int DW = 12,
    parameter int CW = 10,
    parameter int F  = 6,
    parameter int A2 = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [DW-1:0] x_in,
    input  logic signed [DW-1:0] ff_in,
    output logic signed [DW-1:0] y_q
);
    typedef struct packed {
        logic signed [DW-1:0] y;   // y(n-1)
        logic signed [DW-1:0] m;   // T(A2*y(n-2))
    } loop_state_t;

    loop_state_t st;
    logic signed [DW-1:0] m_next;
    logic signed [DW-1:0] y_next;

    lapiir_fx_mul #(.DW(DW), .CW(CW), .F(F), .COEF(A2)) u_mul (
        .din  (st.y),
        .dout (m_next)
    );

    always_comb y_next = x_in + ff_in + st.m;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (en) begin
            st.y <= y_next;
            st.m <= m_next;
        end
    end

    assign y_q = st.y;

    a_r6_loop_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(st));
endmodule

// File: rtl/lapiir_top.sv
module lapiir_top #(
    parameter int DW     = 12,
    parameter int CW     = 10,
    parameter int F      = 6,
    parameter int COEF_A = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] x_in,
    output logic                 out_valid,
    output logic signed [DW-1:0] y_out
);
    import lapiir_pkg::*;

    localparam int COEF_A2 = int'(sq_coef(longint'(COEF_A), F, CW));

    logic signed [DW-1:0] ff_term;
    logic                 vld_q;

    lapiir_ff_path #(.DW(DW), .CW(CW), .F(F), .COEF(COEF_A)) u_ff (
        .clk  (clk),
        .rst  (rst),
        .en   (in_valid),
        .x_in (x_in),
        .ff_q (ff_term)
    );

    lapiir_loop #(.DW(DW), .CW(CW), .F(F), .A2(COEF_A2)) u_loop (
        .clk   (clk),
        .rst   (rst),
        .en    (in_valid),
        .x_in  (x_in),
        .ff_in (ff_term),
        .y_q   (y_out)
    );

    always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= in_valid;
    end

    assign out_valid = vld_q;

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (y_out == '0 && !out_valid));
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r6_output_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(y_out));
endmodule

// File: tb/lapiir_top_tb.sv
module lapiir_top_tb;
    localparam int DW = 12;
    localparam int CW = 10;
    localparam int F  = 6;
    localparam int NI = 4;
    localparam int COEFS [NI] = '{32, -64, 64, -45};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] x_in = '0;
    logic                 v_o [NI];
    logic signed [DW-1:0] y_o [NI];

    always #2 clk = ~clk;

    for (genvar k = 0; k < NI; k++) begin : g_cfg
        lapiir_top #(.DW(DW), .CW(CW), .F(F), .COEF_A(COEFS[k])) u_dut (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid),
            .x_in      (x_in),
            .out_valid (v_o[k]),
            .y_out     (y_o[k])
        );
    end

    int checks = 0;
    int errors = 0;

    longint m_x1 [NI];
    longint m_y1 [NI];
    longint m_y2 [NI];
    longint m_orig [NI];
    longint exp_y [NI];
    bit     exp_v;

    function automatic longint wrapw(input longint v, input int w);
        longint t;
        t = v <<< (64 - w);
        return t >>> (64 - w);
    endfunction

    function automatic longint fx(input longint a, input longint v);
        return wrapw((a * v) >>> F, DW);
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NI; k++) begin
            m_x1[k] = 0; m_y1[k] = 0; m_y2[k] = 0; m_orig[k] = 0; exp_y[k] = 0;
        end
        exp_v = 1'b0;
    endtask

    task automatic chk(input string req, input int k, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s inst %0d actual %0d expected %0d", req, k, act, expv);
        end
    endtask

    task automatic check_outputs();
        for (int k = 0; k < NI; k++) begin
            chk("R2", k, longint'(v_o[k]), longint'(exp_v));
            chk(exp_v ? "R3" : "R6", k, longint'(y_o[k]), exp_y[k]);
            if (exp_v && (COEFS[k] % (1 << F) == 0))
                chk("R7", k, longint'(y_o[k]), m_orig[k]);
        end
    endtask

    task automatic step(input bit v, input longint xv);
        longint a, a2, yn;
        @(negedge clk);
        check_outputs();
        in_valid = v;
        x_in     = DW'(xv);
        if (v) begin
            for (int k = 0; k < NI; k++) begin
                a  = longint'(COEFS[k]);
                a2 = wrapw((a * a) >>> F, CW);
                yn = wrapw(xv + fx(a, m_x1[k]) + fx(a2, m_y2[k]), DW);
                m_y2[k] = m_y1[k];
                m_y1[k] = yn;
                m_x1[k] = xv;
                m_orig[k] = wrapw(xv + fx(a, m_orig[k]), DW);
                exp_y[k] = yn;
            end
        end
        exp_v = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; x_in = '0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < NI; k++) begin
            chk("R1", k, longint'(y_o[k]), 0);
            chk("R1", k, longint'(v_o[k]), 0);
        end
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();

        // R5: zero initial conditions, impulse of 1.0 (64)
        step(1, 64); step(0, 0);
        for (int k = 0; k < NI; k++) chk("R5", k, longint'(y_o[k]), 64);
        step(1, 0); step(0, 0);
        chk("R5", 0, longint'(y_o[0]), 32);
        chk("R5", 1, longint'(y_o[1]), -64);
        chk("R5", 2, longint'(y_o[2]), 64);
        chk("R5", 3, longint'(y_o[3]), -45);
        // R4: third output is T(A2*64), A2 for -45 is 31
        step(1, 0); step(0, 0);
        chk("R4", 0, longint'(y_o[0]), 16);
        chk("R4", 1, longint'(y_o[1]), 64);
        chk("R4", 2, longint'(y_o[2]), 64);
        chk("R4", 3, longint'(y_o[3]), 31);

        // R8: wrap with A = 1.0
        do_reset();
        step(1, 2047); step(1, 2047); step(0, 0);
        chk("R8", 2, longint'(y_o[2]), -2);

        // Sweep all input codes with gaps carrying junk data (R3, R6, R7)
        do_reset();
        for (int i = 0; i < 4096; i++) begin
            longint xv;
            xv = longint'((i * 1237 + 91) % 4096) - 2048;
            if (i == 2500) do_reset();
            if (i % 7 == 3) step(0, -xv);
            step(1, xv);
        end
        step(0, 0);
        step(0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule